// File: doc/BRIEF.md
# Derived-Clock Enable Pulse Narrower

This block takes a write-enable level from a slow clock domain and turns it into a pulse that is exactly one cycle wide in a faster clock domain. The two clocks are produced from one common source. Their rising edges line up, and the fast clock runs at a power-of-two multiple of the slow one. Because of that fixed relationship the crossing is handled as synchronous logic. No metastability synchronizer is placed on the path. Data that travels with the enable is outside the scope of this block.

The slow-side enable is captured on every slow rising edge. One of two gating schemes, chosen by a parameter, then marks a single fast cycle in each slow period. In the counting scheme, a counter on the fast clock steps through the slots of a slow period, and only its final slot is marked. The data then has the longest possible time to settle. In the toggle scheme, a bit in the slow domain flips on every slow edge. The fast side compares that bit with its own copy from the previous fast cycle, and the first fast slot of each slow period is marked. In both schemes the output pulse is the captured enable ANDed with the mark.

Top module: `enable_narrower`

## Requirements
- R1: While reset is low the pulse output stays low. In the slow period during which reset is released, it also stays low.
- R2: In counting mode, a slow period whose captured enable is 1 gives exactly one fast cycle of pulse. A pulse never lasts two fast cycles in a row.
- R3: In counting mode, the pulse falls in the last fast slot of the slow period, slot index RATIO-1, counting the first fast cycle after a slow rising edge as slot 0.
- R4: A slow period whose captured enable is 0 gives no pulse in either mode.
- R5: In toggle mode, a slow period whose captured enable is 1 gives exactly one pulse, in slot 0.
- R6: Slow periods with enable 1 that follow one another give one separate pulse each. Pulses do not merge and none are lost.
- R7: The enable is captured only on the slow rising edge, and the pulse belongs to the slow period that follows that edge. A change of the enable in the middle of a period has no effect until the next slow edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast clock, RATIO times the slow clock, edge aligned |
| clk_slow | input | 1 | Slow derived clock |
| rst_n | input | 1 | Asynchronous active-low reset, released just after a common rising edge |
| slow_wr_en | input | 1 | Write-enable level from the slow domain |
| fast_en_pulse | output | 1 | One-fast-cycle enable pulse |

## Verification
The bench builds two copies of the block with RATIO set to 4, one in counting mode and one in toggle mode. Both copies are driven by the same clocks and the same enable, with a 125 MHz fast clock and a 31.25 MHz slow clock. Every fast slot of every slow period is sampled. With four slots per period, the bench can tell a pulse in the first slot from one in the last, from one in a middle slot, and from a pulse two cycles wide. Runs of enabled periods, isolated enabled periods and enable changes late or early in a period show whether the enable is captured at the slow edge and whether each period gets its own pulse.

// File: rtl/enw_pkg.sv
package enw_pkg;

    // Selects how the fast-domain slot mark is produced.
    typedef enum logic {
        GATE_COUNT  = 1'b0,   // ratio counter, mark on last fast slot
        GATE_TOGGLE = 1'b1    // slow toggle reference, mark on first fast slot
    } gate_mode_e;

endpackage

// File: rtl/enw_slow_capture.sv
module enw_slow_capture (
    input  logic clk_slow,
    input  logic rst_n,
    input  logic wr_en,
    output logic en_q
);

    typedef struct packed {
        logic en;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = wr_en;
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q = st_q.en;

endmodule

// File: rtl/enw_ratio_counter.sv
module enw_ratio_counter #(
    parameter int RATIO = 4
) (
    input  logic clk_fast,
    input  logic rst_n,
    output logic last_slot
);

    localparam int CW = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST     = CW'(RATIO - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(RATIO - 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tc;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        st_d.tc  = (st_d.cnt == LAST);
    end

    // Reset is released just after a slow edge, so count 0 is slot 0.
    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last_slot = st_q.tc;

    // R3: after the terminal slot the count starts a new slow period
    a_r3_wrap_after_last: assert property (@(posedge clk_fast) disable iff (!rst_n)
        st_q.tc |=> (st_q.cnt == '0) && !st_q.tc);

    // R2: the slot before the last is always followed by the mark
    a_r2_mark_follows: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (st_q.cnt == PRE_LAST) |=> st_q.tc);

endmodule

// File: rtl/enw_toggle_ref.sv
module enw_toggle_ref (
    input  logic clk_slow,
    input  logic clk_fast,
    input  logic rst_n,
    output logic slot_start
);

    typedef struct packed {
        logic tog;
    } slow_st_t;

    typedef struct packed {
        logic seen;
    } fast_st_t;

    slow_st_t s_d, s_q;
    fast_st_t f_d, f_q;

    // Slow side: flips on every slow rising edge.
    always_comb begin
        s_d     = s_q;
        s_d.tog = ~s_q.tog;
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Fast side: remembers the reference as seen one fast cycle ago.
    always_comb begin
        f_d      = f_q;
        f_d.seen = s_q.tog;
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign slot_start = s_q.tog ^ f_q.seen;

    // R5: a change of the reference marks one fast slot only
    a_r5_start_single: assert property (@(posedge clk_fast) disable iff (!rst_n)
        slot_start |=> !slot_start);

endmodule

// File: rtl/enable_narrower.sv
module enable_narrower #(
    parameter int                  RATIO = 4,
    parameter enw_pkg::gate_mode_e MODE  = enw_pkg::GATE_COUNT
) (
    input  logic clk_fast,
    input  logic clk_slow,
    input  logic rst_n,
    input  logic slow_wr_en,
    output logic fast_en_pulse
);

    logic en_q;
    logic mark;

    enw_slow_capture u_cap (
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .wr_en    (slow_wr_en),
        .en_q     (en_q)
    );

    generate
        if (MODE == enw_pkg::GATE_COUNT) begin : g_count
            enw_ratio_counter #(.RATIO(RATIO)) u_cnt (
                .clk_fast  (clk_fast),
                .rst_n     (rst_n),
                .last_slot (mark)
            );
        end else begin : g_toggle
            enw_toggle_ref u_tog (
                .clk_slow   (clk_slow),
                .clk_fast   (clk_fast),
                .rst_n      (rst_n),
                .slot_start (mark)
            );
        end
    endgenerate

    assign fast_en_pulse = en_q & mark;

    // R2: the narrowed enable never lasts two fast cycles
    a_r2_single_fast_cycle: assert property (@(posedge clk_fast) disable iff (!rst_n)
        fast_en_pulse |=> !fast_en_pulse);

endmodule

// File: tb/tb_enable_narrower.sv
module tb_enable_narrower;

    localparam int RATIO = 4;
    localparam int N     = 16;
    // Each entry: {enable driven in this period, pulse expected next period}
    localparam logic [1:0] VEC [N] = '{
        2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b11,
        2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00
    };

    logic clk_fast = 1'b0;
    logic clk_slow = 1'b0;
    logic rst_n    = 1'b0;
    logic wr_en    = 1'b0;
    logic pulse_cnt, pulse_tog;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic prev, prev2;

    enable_narrower #(.RATIO(RATIO), .MODE(enw_pkg::GATE_COUNT)) dut (
        .clk_fast (clk_fast), .clk_slow (clk_slow), .rst_n (rst_n),
        .slow_wr_en (wr_en), .fast_en_pulse (pulse_cnt)
    );

    enable_narrower #(.RATIO(RATIO), .MODE(enw_pkg::GATE_TOGGLE)) dut_tog (
        .clk_fast (clk_fast), .clk_slow (clk_slow), .rst_n (rst_n),
        .slow_wr_en (wr_en), .fast_en_pulse (pulse_tog)
    );

    // 125 MHz fast clock; slow clock derived from the same step, edges aligned.
    initial begin
        int h;
        h = RATIO - 1;
        forever begin
            #4;
            clk_fast = ~clk_fast;
            h = h + 1;
            if (h == RATIO) begin
                clk_slow = ~clk_slow;
                h = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One slow period: sample every fast slot, optionally drive the enable.
    task automatic run_period(input logic p, input logic pp,
                              input int drive_j, input logic drive_val);
        @(posedge clk_slow);
        for (int j = 0; j < RATIO; j++) begin
            @(negedge clk_fast);
            if (!p) begin
                chk("R4 idle period, counting mode", pulse_cnt, 1'b0);
                chk("R4 idle period, toggle mode", pulse_tog, 1'b0);
            end else begin
                if (j == RATIO - 1)
                    chk(pp ? "R6 back-to-back, counting last slot" : "R3 counting last slot",
                        pulse_cnt, 1'b1);
                else
                    chk("R2 counting single pulse", pulse_cnt, 1'b0);
                if (j == 0)
                    chk(pp ? "R6 back-to-back, toggle first slot" : "R5 toggle first slot",
                        pulse_tog, 1'b1);
                else
                    chk("R5 toggle single pulse", pulse_tog, 1'b0);
            end
            if (j == drive_j) wr_en = drive_val;
        end
    endtask

    initial begin
        // R1: reset holds the output low even with the enable high
        wr_en = 1'b1;
        repeat (2) @(posedge clk_slow);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk_fast);
            chk("R1 reset counting", pulse_cnt, 1'b0);
            chk("R1 reset toggle", pulse_tog, 1'b0);
        end
        wr_en = 1'b0;
        @(posedge clk_slow);
        #1 rst_n = 1'b1;
        for (int j = 0; j < RATIO; j++) begin
            @(negedge clk_fast);
            chk("R1 release period counting", pulse_cnt, 1'b0);
            chk("R1 release period toggle", pulse_tog, 1'b0);
        end

        // Vector table walk
        prev  = 1'b0;
        prev2 = 1'b0;
        for (int i = 0; i <= N; i++) begin
            if (i < N) run_period(prev, prev2, 1, VEC[i][1]);
            else       run_period(prev, prev2, -1, 1'b0);
            prev2 = prev;
            prev  = (i < N) ? VEC[i][0] : 1'b0;
        end

        // R7: enable raised in the final slot, dropped in slot 0 of the next period
        run_period(prev, prev2, RATIO - 1, 1'b1);    // captured enable 0 here
        run_period(1'b1, 1'b0, 0, 1'b0);            // R7: still one pulse in each mode
        run_period(1'b0, 1'b1, -1, 1'b0);           // R7: the drop takes effect here

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule